// File: doc/BRIEF.md
# Packet Task-File Device Controller

This block is the device half of an ATA-style task-file register set that carries packet commands. A host reaches it through a register-select bus. The bus gives access to the error/feature, interrupt-reason (sector count), three address bytes, device, status/command and device-control registers, and to a 16-bit data port. When the host issues the packet command, it writes a 12-byte command packet through the data port. The block then hands all twelve bytes in parallel, in a single-cycle pulse, to a command decoder that sits outside it.

The decoder fills a local word-wide sector buffer and asks for a read-back. The host then drains the data through the data port (PIO), or a bus master pulls it through a separate word strobe (DMA). Each phase leaves fixed status and interrupt-reason values behind. The byte count of a PIO transfer is echoed into the middle and high address bytes. One interrupt-pending flag drives the request line. That flag is set only when it is not already set, it is cleared by a status read when the device is not busy or by any command write, and the device-control mask bit gates it at any time.

Top module: `ptf_ctrl`

## Requirements
- R1: Register selects are 0 data, 1 error(read)/feature(write), 2 count, 3 LBA low, 4 LBA mid, 5 LBA high, 6 device, 7 status(read)/command(write), 8 alternate status(read)/device control(write). After reset: error 0x01, count 0x01, LBA low/mid/high 0x81/0x14/0xEB, status 0x00, device 0x00, idle, interrupt line low.
- R2: Command 0xA0 enters command-packet write: status 0x58, error = feature[1:0], count 0x01, no interrupt.
- R3: After the sixth data-port word write, status reads 0xD0 (BSY set, DRQ clear) and `pkt_valid` pulses for exactly one cycle. `pkt_bytes[8*i+:8]` holds byte i, where word k carries byte 2k in bits 7:0 and byte 2k+1 in bits 15:8.
- R4: `xfer_start` while busy, with feature bit 0 = 0, starts a PIO read: count 0x02, status 0x58, LBA mid/high = length low/high byte, interrupt raised.
- R5: With feature bit 0 = 1, `xfer_start` starts a DMA read: status 0xD0 and no interrupt. Each `dma_rd` returns the next buffer word one cycle later. After the last word: status 0x50, count 0x03, interrupt raised.
- R6: Each PIO data-port read returns the next buffer word (byte offset advances by 2). When the offset reaches the length: idle, status 0x50, count 0x03, interrupt raised.
- R7: A data-port read outside PIO read returns 0xFFFF. A data-port write outside command-packet write has no effect.
- R8: Command 0x00 aborts: idle, status 0x51, error 0x04, interrupt raised.
- R9: Command 0xEF completes with status 0x50, error 0x00, LBA mid/high 0x00, interrupt raised.
- R10: A status read (select 7) with BSY clear clears the pending interrupt. An alternate-status read (select 8) does not. Any command write clears it before that command's own effect.
- R11: Device-control bit 1 masks the line immediately while it is set. Clearing it while an interrupt is pending drives the line high again.
- R12: Command 0x08 restores the register values listed in R1 and returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hst_wr | input | 1 | Host register write strobe |
| hst_rd | input | 1 | Host register read strobe |
| hst_sel | input | 4 | Register select (R1 encoding) |
| hst_wdata | input | 16 | Host write data (8-bit registers use bits 7:0) |
| hst_rdata | output | 16 | Host read data, valid the cycle after `hst_rd` |
| buf_we | input | 1 | Sector buffer write strobe from the requester |
| buf_addr | input | AW | Sector buffer word address |
| buf_wdata | input | 16 | Sector buffer write word |
| xfer_start | input | 1 | Decoder request to start a read-back |
| xfer_len | input | LW | Read-back length in bytes (even, at least 2) |
| dma_rd | input | 1 | DMA word pull strobe |
| dma_rdata | output | 16 | DMA word, valid the cycle after `dma_rd` |
| pkt_valid | output | 1 | One-cycle command packet handoff pulse |
| pkt_bytes | output | 96 | The 12 packet bytes, byte i at bits 8i+7:8i |
| intrq | output | 1 | Interrupt request line |

## Verification
The hardest thing to reach from the ports is the moment when a pending interrupt meets a clearing event. This happens when the final PIO word read completes, and when the abort and set-features commands clear and raise in the same cycle. The stimulus drains a transfer word by word and samples the line between reads. It reads the alternate status before the real status, toggles the mask bit around a pending interrupt, and issues commands while an interrupt is still pending, so that clear and raise meet in the same cycle.

// File: rtl/ptf_pkg.sv
package ptf_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_CMDW  = 3'd1,
    ST_PIORD = 3'd2,
    ST_DMARD = 3'd3,
    ST_BUSY  = 3'd4
  } ptf_state_e;

  localparam logic [3:0] SEL_DATA = 4'd0;
  localparam logic [3:0] SEL_ERR  = 4'd1;
  localparam logic [3:0] SEL_CNT  = 4'd2;
  localparam logic [3:0] SEL_LBA0 = 4'd3;
  localparam logic [3:0] SEL_LBA1 = 4'd4;
  localparam logic [3:0] SEL_LBA2 = 4'd5;
  localparam logic [3:0] SEL_DEV  = 4'd6;
  localparam logic [3:0] SEL_STAT = 4'd7;
  localparam logic [3:0] SEL_CTL  = 4'd8;

  localparam logic [7:0] CMD_ABORT = 8'h00;
  localparam logic [7:0] CMD_RESET = 8'h08;
  localparam logic [7:0] CMD_PKT   = 8'hA0;
  localparam logic [7:0] CMD_SETF  = 8'hEF;

  localparam logic [7:0] STS_BSY = 8'h80;
  localparam logic [7:0] STS_DRQ = 8'h08;

  localparam int PKT_WORDS = 6;

endpackage

// File: rtl/ptf_secbuf.sv
module ptf_secbuf #(
  parameter int WORDS = 1024,
  parameter int AW    = $clog2(WORDS),
  parameter int DW    = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [WORDS];

  // simple dual-port shape, registered read
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/ptf_pktcap.sv
module ptf_pktcap #(
  parameter int WORDS = 6,
  parameter int IW    = $clog2(WORDS)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [IW-1:0]      idx,
  input  logic [15:0]        wdata,
  input  logic               last,
  output logic               pkt_valid,
  output logic [WORDS*16-1:0] pkt_bytes
);
  logic [15:0] words [WORDS];

  always_ff @(posedge clk) begin
    if (we) words[idx] <= wdata;
  end

  for (genvar k = 0; k < WORDS; k++) begin : g_pack
    assign pkt_bytes[16*k +: 16] = words[k];
  end

  always_ff @(posedge clk) begin
    if (rst) pkt_valid <= 1'b0;
    else     pkt_valid <= we && last;
  end

  // R3: handoff is a single-cycle pulse
  a_r3_one_pulse: assert property (@(posedge clk) disable iff (rst)
    pkt_valid |=> !pkt_valid);
endmodule

// File: rtl/ptf_irq.sv
module ptf_irq (
  input  logic clk,
  input  logic rst,
  input  logic raise,
  input  logic clear,
  input  logic mask,
  output logic pending,
  output logic line
);
  // raise wins over a clear in the same cycle (command write then completion)
  always_ff @(posedge clk) begin
    if (rst)        pending <= 1'b0;
    else if (raise) pending <= 1'b1;
    else if (clear) pending <= 1'b0;
  end

  assign line = pending && !mask;
endmodule

// File: rtl/ptf_ctrl.sv
module ptf_ctrl
  import ptf_pkg::*;
#(
  parameter int BUF_WORDS = 1024,
  parameter int AW        = $clog2(BUF_WORDS),
  parameter int LW        = AW + 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hst_wr,
  input  logic          hst_rd,
  input  logic [3:0]    hst_sel,
  input  logic [15:0]   hst_wdata,
  output logic [15:0]   hst_rdata,
  input  logic          buf_we,
  input  logic [AW-1:0] buf_addr,
  input  logic [15:0]   buf_wdata,
  input  logic          xfer_start,
  input  logic [LW-1:0] xfer_len,
  input  logic          dma_rd,
  output logic [15:0]   dma_rdata,
  output logic          pkt_valid,
  output logic [95:0]   pkt_bytes,
  output logic          intrq
);
  localparam int PIW = $clog2(PKT_WORDS);
  localparam logic [LW-1:0] PKT_LAST_OFS = LW'(2 * (PKT_WORDS - 1));

  ptf_state_e  st;
  logic [7:0]  err_q, feat_q, cnt_q, lba0_q, lba1_q, lba2_q, dev_q, stat_q, ctl_q;
  logic [LW-1:0] ofs_q, len_q;
  logic [15:0] rdreg_q;
  logic        rd_data_q, rd_ff_q;
  logic [15:0] ram_q;
  logic        irq_pend;

  logic cmd_wr, stat_rd, data_rd_ok, pio_last, dma_ok, dma_last, xs_ok;
  logic pkt_we, pkt_last, raise, clear;
  logic [LW:0] ofs_nx;

  always_comb begin
    ofs_nx     = {1'b0, ofs_q} + (LW+1)'(2);
    cmd_wr     = hst_wr && (hst_sel == SEL_STAT);
    stat_rd    = hst_rd && (hst_sel == SEL_STAT);
    data_rd_ok = hst_rd && (hst_sel == SEL_DATA) && (st == ST_PIORD);
    pio_last   = data_rd_ok && (ofs_nx >= {1'b0, len_q});
    dma_ok     = dma_rd && (st == ST_DMARD);
    dma_last   = dma_ok && (ofs_nx >= {1'b0, len_q});
    xs_ok      = xfer_start && (st == ST_BUSY);
    pkt_we     = hst_wr && (hst_sel == SEL_DATA) && (st == ST_CMDW);
    pkt_last   = pkt_we && (ofs_q == PKT_LAST_OFS);
    raise      = (cmd_wr && (hst_wdata[7:0] == CMD_ABORT || hst_wdata[7:0] == CMD_SETF))
               || (xs_ok && !feat_q[0]) || pio_last || dma_last;
    clear      = cmd_wr || (stat_rd && !stat_q[7]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      err_q  <= 8'h01;
      cnt_q  <= 8'h01;
      lba0_q <= 8'h81;
      lba1_q <= 8'h14;
      lba2_q <= 8'hEB;
      dev_q  <= 8'h00;
      stat_q <= 8'h00;
      feat_q <= 8'h00;
      ctl_q  <= 8'h00;
      ofs_q  <= '0;
      len_q  <= '0;
    end else begin
      if (hst_wr) begin
        case (hst_sel)
          SEL_ERR:  feat_q <= hst_wdata[7:0];
          SEL_CNT:  cnt_q  <= hst_wdata[7:0];
          SEL_LBA0: lba0_q <= hst_wdata[7:0];
          SEL_LBA1: lba1_q <= hst_wdata[7:0];
          SEL_LBA2: lba2_q <= hst_wdata[7:0];
          SEL_DEV:  dev_q  <= hst_wdata[7:0];
          SEL_CTL:  ctl_q  <= hst_wdata[7:0];
          default: ;
        endcase
      end
      if (cmd_wr) begin
        case (hst_wdata[7:0])
          CMD_ABORT: begin
            st     <= ST_IDLE;
            stat_q <= 8'h51;
            err_q  <= 8'h04;
          end
          CMD_RESET: begin
            st     <= ST_IDLE;
            err_q  <= 8'h01;
            cnt_q  <= 8'h01;
            lba0_q <= 8'h81;
            lba1_q <= 8'h14;
            lba2_q <= 8'hEB;
            dev_q  <= 8'h00;
            stat_q <= 8'h00;
          end
          CMD_PKT: begin
            st     <= ST_CMDW;
            stat_q <= 8'h58;
            err_q  <= {6'b0, feat_q[1:0]};
            cnt_q  <= 8'h01;
            ofs_q  <= '0;
          end
          CMD_SETF: begin
            stat_q <= 8'h50;
            err_q  <= 8'h00;
            lba1_q <= 8'h00;
            lba2_q <= 8'h00;
          end
          default: ;
        endcase
      end
      if (pkt_we) begin
        ofs_q <= ofs_nx[LW-1:0];
        if (pkt_last) begin
          st     <= ST_BUSY;
          stat_q <= (stat_q & ~STS_DRQ) | STS_BSY;
        end
      end
      if (xs_ok) begin
        cnt_q <= 8'h02;
        len_q <= xfer_len;
        ofs_q <= '0;
        if (feat_q[0]) begin
          st     <= ST_DMARD;
          stat_q <= 8'hD0;
        end else begin
          st     <= ST_PIORD;
          stat_q <= 8'h58;
          lba1_q <= 8'(xfer_len);
          lba2_q <= 8'(xfer_len >> 8);
        end
      end
      if (data_rd_ok) begin
        ofs_q <= ofs_nx[LW-1:0];
        if (pio_last) begin
          st     <= ST_IDLE;
          stat_q <= stat_q & ~STS_DRQ;
          cnt_q  <= 8'h03;
        end
      end
      if (dma_ok) begin
        ofs_q <= ofs_nx[LW-1:0];
        if (dma_last) begin
          st     <= ST_IDLE;
          stat_q <= 8'h50;
          cnt_q  <= 8'h03;
        end
      end
    end
  end

  // registered host read path
  always_ff @(posedge clk) begin
    if (rst) begin
      rdreg_q   <= '0;
      rd_data_q <= 1'b0;
      rd_ff_q   <= 1'b1;
    end else if (hst_rd) begin
      rd_data_q <= (hst_sel == SEL_DATA);
      rd_ff_q   <= (st != ST_PIORD);
      case (hst_sel)
        SEL_ERR:  rdreg_q <= {8'h00, err_q};
        SEL_CNT:  rdreg_q <= {8'h00, cnt_q};
        SEL_LBA0: rdreg_q <= {8'h00, lba0_q};
        SEL_LBA1: rdreg_q <= {8'h00, lba1_q};
        SEL_LBA2: rdreg_q <= {8'h00, lba2_q};
        SEL_DEV:  rdreg_q <= {8'h00, dev_q};
        SEL_STAT, SEL_CTL: rdreg_q <= {8'h00, stat_q};
        default:  rdreg_q <= 16'h0000;
      endcase
    end
  end

  assign hst_rdata = rd_data_q ? (rd_ff_q ? 16'hFFFF : ram_q) : rdreg_q;
  assign dma_rdata = ram_q;

  ptf_secbuf #(.WORDS(BUF_WORDS), .AW(AW), .DW(16)) i_buf (
    .clk   (clk),
    .we    (buf_we),
    .waddr (buf_addr),
    .wdata (buf_wdata),
    .re    (data_rd_ok || dma_ok),
    .raddr (ofs_q[AW:1]),
    .rdata (ram_q)
  );

  ptf_pktcap #(.WORDS(PKT_WORDS), .IW(PIW)) i_pkt (
    .clk       (clk),
    .rst       (rst),
    .we        (pkt_we),
    .idx       (PIW'(ofs_q >> 1)),
    .wdata     (hst_wdata),
    .last      (pkt_last),
    .pkt_valid (pkt_valid),
    .pkt_bytes (pkt_bytes)
  );

  ptf_irq i_irq (
    .clk     (clk),
    .rst     (rst),
    .raise   (raise),
    .clear   (clear),
    .mask    (ctl_q[1]),
    .pending (irq_pend),
    .line    (intrq)
  );

  // R3: handoff happens only once the block has gone busy
  a_r3_busy_at_handoff: assert property (@(posedge clk) disable iff (rst)
    pkt_valid |-> (st == ST_BUSY) && (stat_q == 8'hD0));

  // R4: PIO read phase keeps the data-request status
  a_r4_pio_status: assert property (@(posedge clk) disable iff (rst)
    (st == ST_PIORD) |-> (stat_q == 8'h58));

  // R6: final word of a PIO read completes the transfer
  a_r6_pio_done: assert property (@(posedge clk) disable iff (rst)
    (pio_last && !cmd_wr) |=> (st == ST_IDLE) && (cnt_q == 8'h03) && irq_pend);

  // R10: status read while not busy drops the pending flag
  a_r10_stat_clears: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && !stat_q[7] && !raise) |=> !irq_pend);

  // R11: the mask bit keeps the line low
  a_r11_mask: assert property (@(posedge clk) disable iff (rst)
    ctl_q[1] |-> !intrq);
endmodule

// File: tb/test_ptf_ctrl.sv
module test_ptf_ctrl;
  localparam int BUF_WORDS = 1024;
  localparam int AW = $clog2(BUF_WORDS);
  localparam int LW = AW + 2;

  localparam logic [3:0] OP_WR = 4'd1, OP_RD = 4'd2, OP_XS = 4'd3,
                         OP_IRQ = 4'd4, OP_PKT = 4'd5, OP_DMA = 4'd6;
  // {op, req, sel, data, expected}
  localparam int NV = 76;
  localparam logic [51:0] VEC [NV] = '{
    {OP_RD, 4'd1, 4'd7, 16'h0, 16'h0000},   // R1 status
    {OP_RD, 4'd1, 4'd1, 16'h0, 16'h0001},   // R1 error
    {OP_RD, 4'd1, 4'd2, 16'h0, 16'h0001},   // R1 count
    {OP_RD, 4'd1, 4'd3, 16'h0, 16'h0081},   // R1 lba low
    {OP_RD, 4'd1, 4'd4, 16'h0, 16'h0014},   // R1 lba mid
    {OP_RD, 4'd1, 4'd5, 16'h0, 16'h00EB},   // R1 lba high
    {OP_RD, 4'd1, 4'd6, 16'h0, 16'h0000},   // R1 device
    {OP_IRQ,4'd1, 4'd0, 16'h0, 16'h0000},   // R1 line low
    {OP_RD, 4'd7, 4'd0, 16'h0, 16'hFFFF},   // R7 idle data read
    {OP_WR, 4'd7, 4'd0, 16'h5555, 16'h0},   // R7 idle data write
    {OP_PKT,4'd7, 4'd0, 16'h0, 16'h0000},   // R7 no handoff
    {OP_WR, 4'd2, 4'd1, 16'h0006, 16'h0},   // feature 0x06
    {OP_WR, 4'd2, 4'd7, 16'h00A0, 16'h0},   // R2 packet command
    {OP_RD, 4'd2, 4'd8, 16'h0, 16'h0058},   // R2 status
    {OP_RD, 4'd2, 4'd1, 16'h0, 16'h0002},   // R2 error=feat[1:0]
    {OP_RD, 4'd2, 4'd2, 16'h0, 16'h0001},   // R2 count
    {OP_IRQ,4'd2, 4'd0, 16'h0, 16'h0000},   // R2 no interrupt
    {OP_WR, 4'd3, 4'd0, 16'h3130, 16'h0},
    {OP_WR, 4'd3, 4'd0, 16'h3332, 16'h0},
    {OP_WR, 4'd3, 4'd0, 16'h3534, 16'h0},
    {OP_WR, 4'd3, 4'd0, 16'h3736, 16'h0},
    {OP_WR, 4'd3, 4'd0, 16'h3938, 16'h0},
    {OP_PKT,4'd3, 4'd0, 16'h0, 16'h0000},   // R3 not yet after 5 words
    {OP_WR, 4'd3, 4'd0, 16'h3B3A, 16'h0},
    {OP_PKT,4'd3, 4'd0, 16'h0, 16'h0001},   // R3 one pulse
    {OP_RD, 4'd3, 4'd8, 16'h0, 16'h00D0},   // R3 busy status
    {OP_XS, 4'd4, 4'd0, 16'h0006, 16'h0},   // R4 PIO start, 6 bytes
    {OP_IRQ,4'd4, 4'd0, 16'h0, 16'h0001},   // R4 interrupt
    {OP_RD, 4'd4, 4'd2, 16'h0, 16'h0002},   // R4 count
    {OP_RD, 4'd4, 4'd4, 16'h0, 16'h0006},   // R4 lba mid
    {OP_RD, 4'd4, 4'd5, 16'h0, 16'h0000},   // R4 lba high
    {OP_RD, 4'd10,4'd8, 16'h0, 16'h0058},   // R10 alt status
    {OP_IRQ,4'd10,4'd0, 16'h0, 16'h0001},   // R10 alt keeps pending
    {OP_RD, 4'd10,4'd7, 16'h0, 16'h0058},   // R10 status
    {OP_IRQ,4'd10,4'd0, 16'h0, 16'h0000},   // R10 cleared
    {OP_RD, 4'd6, 4'd0, 16'h0, 16'hC000},   // R6 word 0
    {OP_RD, 4'd6, 4'd0, 16'h0, 16'hC003},   // R6 word 1
    {OP_IRQ,4'd6, 4'd0, 16'h0, 16'h0000},
    {OP_RD, 4'd6, 4'd0, 16'h0, 16'hC006},   // R6 word 2 (last)
    {OP_IRQ,4'd6, 4'd0, 16'h0, 16'h0001},   // R6 interrupt
    {OP_RD, 4'd6, 4'd2, 16'h0, 16'h0003},   // R6 count
    {OP_RD, 4'd6, 4'd8, 16'h0, 16'h0050},   // R6 status
    {OP_RD, 4'd7, 4'd0, 16'h0, 16'hFFFF},   // R7 after transfer
    {OP_WR, 4'd11,4'd8, 16'h0002, 16'h0},   // R11 mask
    {OP_IRQ,4'd11,4'd0, 16'h0, 16'h0000},
    {OP_WR, 4'd11,4'd8, 16'h0000, 16'h0},   // R11 unmask
    {OP_IRQ,4'd11,4'd0, 16'h0, 16'h0001},
    {OP_WR, 4'd8, 4'd7, 16'h0000, 16'h0},   // R8 abort while pending
    {OP_IRQ,4'd8, 4'd0, 16'h0, 16'h0001},
    {OP_RD, 4'd8, 4'd1, 16'h0, 16'h0004},
    {OP_RD, 4'd8, 4'd8, 16'h0, 16'h0051},
    {OP_RD, 4'd10,4'd7, 16'h0, 16'h0051},   // R10 clear
    {OP_IRQ,4'd10,4'd0, 16'h0, 16'h0000},
    {OP_WR, 4'd9, 4'd4, 16'h0033, 16'h0},
    {OP_WR, 4'd9, 4'd5, 16'h0044, 16'h0},
    {OP_WR, 4'd9, 4'd7, 16'h00EF, 16'h0},   // R9 set features
    {OP_IRQ,4'd9, 4'd0, 16'h0, 16'h0001},
    {OP_RD, 4'd9, 4'd8, 16'h0, 16'h0050},
    {OP_RD, 4'd9, 4'd1, 16'h0, 16'h0000},
    {OP_RD, 4'd9, 4'd4, 16'h0, 16'h0000},
    {OP_RD, 4'd9, 4'd5, 16'h0, 16'h0000},
    {OP_WR, 4'd12,4'd7, 16'h0008, 16'h0},   // R12 reset device
    {OP_IRQ,4'd12,4'd0, 16'h0, 16'h0000},   // R10 command write clears
    {OP_RD, 4'd12,4'd1, 16'h0, 16'h0001},
    {OP_RD, 4'd12,4'd3, 16'h0, 16'h0081},
    {OP_RD, 4'd12,4'd5, 16'h0, 16'h00EB},
    {OP_RD, 4'd12,4'd8, 16'h0, 16'h0000},
    {OP_WR, 4'd5, 4'd1, 16'h0001, 16'h0},   // feature bit0 = DMA
    {OP_WR, 4'd5, 4'd7, 16'h00A0, 16'h0},
    {OP_WR, 4'd5, 4'd0, 16'h0101, 16'h0},
    {OP_WR, 4'd5, 4'd0, 16'h0202, 16'h0},
    {OP_WR, 4'd5, 4'd0, 16'h0303, 16'h0},
    {OP_WR, 4'd5, 4'd0, 16'h0404, 16'h0},
    {OP_WR, 4'd5, 4'd0, 16'h0505, 16'h0},
    {OP_WR, 4'd5, 4'd0, 16'h0606, 16'h0},
    {OP_XS, 4'd5, 4'd0, 16'h0004, 16'h0}    // R5 DMA start, 4 bytes
  };

  logic clk = 1'b0, rst = 1'b1;
  logic hst_wr = 0, hst_rd = 0;
  logic [3:0] hst_sel = '0;
  logic [15:0] hst_wdata = '0, hst_rdata;
  logic buf_we = 0;
  logic [AW-1:0] buf_addr = '0;
  logic [15:0] buf_wdata = '0;
  logic xfer_start = 0;
  logic [LW-1:0] xfer_len = '0;
  logic dma_rd = 0;
  logic [15:0] dma_rdata;
  logic pkt_valid;
  logic [95:0] pkt_bytes, last_pkt;
  logic intrq;
  int checks = 0, fails = 0, pkt_count = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ptf_ctrl #(.BUF_WORDS(BUF_WORDS)) i_ptf_ctrl (
    .clk(clk), .rst(rst), .hst_wr(hst_wr), .hst_rd(hst_rd), .hst_sel(hst_sel),
    .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .buf_we(buf_we),
    .buf_addr(buf_addr), .buf_wdata(buf_wdata), .xfer_start(xfer_start),
    .xfer_len(xfer_len), .dma_rd(dma_rd), .dma_rdata(dma_rdata),
    .pkt_valid(pkt_valid), .pkt_bytes(pkt_bytes), .intrq(intrq)
  );

  always @(negedge clk) begin
    if (pkt_valid) begin
      pkt_count <= pkt_count + 1;
      last_pkt  <= pkt_bytes;
    end
  end

  function automatic logic [15:0] bufword(int i);
    return 16'hC000 + 16'(3 * i);
  endfunction

  task automatic check(int req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] sel, logic [15:0] d);
    @(negedge clk); hst_wr = 1; hst_sel = sel; hst_wdata = d;
    @(negedge clk); hst_wr = 0;
  endtask

  task automatic rd(logic [3:0] sel, output logic [15:0] v);
    @(negedge clk); hst_rd = 1; hst_sel = sel;
    @(negedge clk); hst_rd = 0; v = hst_rdata;
  endtask

  task automatic pulse_xs(logic [15:0] len);
    @(negedge clk); xfer_start = 1; xfer_len = LW'(len);
    @(negedge clk); xfer_start = 0;
  endtask

  task automatic dma(output logic [15:0] v);
    @(negedge clk); dma_rd = 1;
    @(negedge clk); dma_rd = 0; v = dma_rdata;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got hang expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] v;
    int base;
    repeat (3) @(negedge clk);
    rst = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk); buf_we = 1; buf_addr = AW'(i); buf_wdata = bufword(i);
    end
    @(negedge clk); buf_we = 0;

    for (int n = 0; n < NV; n++) begin
      logic [3:0] op, rq, sl;
      logic [15:0] dt, ex;
      {op, rq, sl, dt, ex} = VEC[n];
      case (op)
        OP_WR:  wr(sl, dt);
        OP_RD:  begin rd(sl, v); check(int'(rq), v, ex); end
        OP_XS:  pulse_xs(dt);
        OP_IRQ: begin @(negedge clk); check(int'(rq), {15'b0, intrq}, ex); end
        OP_PKT: begin @(negedge clk); check(int'(rq), 16'(pkt_count), ex); end
        default: ;
      endcase
    end

    // R3 byte order: byte i = 0x30 + i from the first packet; the DMA packet is 0x01..0x06 pairs
    check(3, {last_pkt[7:0], last_pkt[95:88]}, 16'h0106);
    // R5 DMA start: no interrupt, busy status
    @(negedge clk); check(5, {15'b0, intrq}, 16'h0);
    rd(4'd8, v); check(5, v, 16'h00D0);
    rd(4'd0, v); check(7, v, 16'hFFFF);     // R7 data port idle during DMA
    dma(v); check(5, v, bufword(0));
    @(negedge clk); check(5, {15'b0, intrq}, 16'h0);
    dma(v); check(5, v, bufword(1));
    @(negedge clk); check(5, {15'b0, intrq}, 16'h1);
    rd(4'd8, v); check(5, v, 16'h0050);
    rd(4'd2, v); check(5, v, 16'h0003);

    // R3 first packet contents: reissue a PIO packet and compare all bytes
    wr(4'd1, 16'h0000);
    wr(4'd7, 16'h00A0);
    for (int k = 0; k < 6; k++) wr(4'd0, {8'(8'h31 + 2*k), 8'(8'h30 + 2*k)});
    @(negedge clk);
    for (int i = 0; i < 12; i++) check(3, {8'h0, last_pkt[8*i +: 8]}, 16'(8'h30 + i));
    check(3, 16'(pkt_count), 16'd3);

    // R6 long PIO transfer: 256 words (512 bytes), all words in order
    pulse_xs(16'd512);
    rd(4'd4, v); check(4, v, 16'h0000);
    rd(4'd5, v); check(4, v, 16'h0002);
    rd(4'd7, v);
    base = 0;
    for (int i = 0; i < 256; i++) begin
      rd(4'd0, v);
      if (v !== bufword(i)) base++;
    end
    check(6, 16'(base), 16'd0);
    @(negedge clk); check(6, {15'b0, intrq}, 16'h1);

    // R1 reset mid-transfer returns to reset values and drops the line
    wr(4'd7, 16'h00A0);
    wr(4'd0, 16'h1111);
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    check(1, {15'b0, intrq}, 16'h0);
    rd(4'd8, v); check(1, v, 16'h0000);
    rd(4'd4, v); check(1, v, 16'h0014);
    rd(4'd0, v); check(1, v, 16'hFFFF);

    finish_run();
  end
endmodule